// File: doc/BRIEF.md
# Serial Receive Queue with Programmable Fill Trigger

This block buffers received serial characters between a deserializer and the software that drains them. It holds up to 16 bytes in arrival order. A byte offered by the deserializer is stored only while the receiver is enabled. Bytes offered while the receiver is disabled are thrown away. Each bus read of the data port removes the oldest byte. A read of an empty queue returns zero and changes nothing.

Two notification flags tell software how much work is waiting. The fill flag is raised by a store that brings the occupancy up to a programmable level. The ready flag is raised by a store that leaves the occupancy below that level. The level comes from one of two sources. The first is a 2-bit code that selects 1, 4, 8 or 14 entries. The second is a 5-bit direct count, and a select bit picks it in place of the code. Software clears the flags by writing zero to them. A drain also clears them, as the requirements below describe. A flush pulse empties the queue in one cycle. A store attempted while the queue holds 16 bytes is lost and raises a sticky overrun flag. The occupancy is reported as a 5-bit count.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: The queue holds 16 bytes of 8 bits and returns them in arrival order. `occupancy` is the current byte count and never exceeds 16.
- R2: While `rx_en` is 0, a byte offered on `in_valid` is discarded. `occupancy` and the flags do not change.
- R3: While the select bit is 0, the level comes from the code: code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 14.
- R4: While the select bit is 1, the level is the 5-bit direct count. After reset the code is 0, the select bit is 0 and the direct count is 0x1F. The code and select bit are written by `mode_wr`. The direct count is written separately by `count_wr`.
- R5: After an accepted store, if the new occupancy is at or above the level, `full_flag` is set. Otherwise `ready_flag` is set.
- R6: A read of a non-empty queue clears `full_flag`. If that read leaves the queue empty, it also clears `ready_flag`.
- R7: While the queue is empty, `rd_data` is 0x00. A read of an empty queue changes no state.
- R8: A `flush` pulse empties the queue. It leaves the flags unchanged, and a store or read in the same cycle is ignored.
- R9: A store attempted while the queue holds 16 bytes (with no read in the same cycle) is dropped and sets `overrun_flag`. That flag clears only when software writes 0 to it.
- R10: A status write (`st_wr`) clears each flag whose write bit is 0 and leaves unchanged each flag whose write bit is 1. A store, read or overrun in the same cycle is applied after the clear.
- R11: After reset, the queue is empty and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; stores are accepted only while it is 1 |
| in_valid | input | 1 | Deserializer offers a byte this cycle |
| in_byte | input | 8 | Offered byte |
| rd_pop | input | 1 | Bus read of the data port; removes the oldest byte |
| rd_data | output | 8 | Oldest byte, or 0x00 while the queue is empty |
| flush | input | 1 | Empties the queue |
| st_wr | input | 1 | Status write strobe |
| st_ready_wr | input | 1 | Write bit for the ready flag (0 clears it) |
| st_full_wr | input | 1 | Write bit for the fill flag (0 clears it) |
| st_ovr_wr | input | 1 | Write bit for the overrun flag (0 clears it) |
| mode_wr | input | 1 | Writes the level code and the select bit |
| mode_code | input | 2 | Level code (0:1, 1:4, 2:8, 3:14) |
| mode_sel | input | 1 | 1 selects the direct count |
| count_wr | input | 1 | Writes the direct count |
| count_val | input | 5 | Direct count value |
| occupancy | output | 5 | Bytes held |
| ready_flag | output | 1 | Data-ready flag |
| full_flag | output | 1 | Level-reached flag |
| overrun_flag | output | 1 | Sticky overrun flag |

## Verification
`rd_data` is combinational from the head entry, so it is valid in the same cycle that the read strobe is presented. The bench samples it just before it raises `rd_pop`. A store, read, flush, status write or configuration write takes effect at the next rising edge. `occupancy` and all three flags therefore change one edge after the stimulus. Each bench operation holds its stimulus from one falling edge to the next, then samples at the falling edge, half a period after the register update. A configuration write is always issued one full cycle before the store whose flag result depends on it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned LVL_W = 5;

  typedef enum logic [1:0] {
    LVL_ONE      = 2'd0,
    LVL_FOUR     = 2'd1,
    LVL_EIGHT    = 2'd2,
    LVL_FOURTEEN = 2'd3
  } lvl_code_e;

  typedef struct packed {
    logic ready;
    logic full;
    logic ovr;
  } rxq_flags_t;

  function automatic logic [LVL_W-1:0] code_level(lvl_code_e c);
    logic [LVL_W-1:0] v;
    case (c)
      LVL_ONE:   v = LVL_W'(1);
      LVL_FOUR:  v = LVL_W'(4);
      LVL_EIGHT: v = LVL_W'(8);
      default:   v = LVL_W'(14);
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rxq_cfg.sv
module rxq_cfg
  import rxq_pkg::*;
#(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned CNT_RST = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [1:0]       mode_code,
  input  logic             mode_sel,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] count_val,
  output logic [CNT_W-1:0] level
);

  lvl_code_e        code_q, code_d;
  logic             sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    code_d = code_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    if (mode_wr) begin
      code_d = lvl_code_e'(mode_code);
      sel_d  = mode_sel;
    end
    if (count_wr) begin
      cnt_d = count_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= LVL_ONE;
      sel_q  <= 1'b0;
      cnt_q  <= CNT_W'(CNT_RST);
    end else begin
      code_q <= code_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
    end
  end

  assign level = sel_q ? cnt_q : CNT_W'(code_level(code_q));

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic              do_flush,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  count_next
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_d       = wr_q;
    rd_d       = rd_q;
    count_next = cnt_q;
    if (do_flush) begin
      wr_d       = '0;
      rd_d       = '0;
      count_next = '0;
    end else begin
      if (do_push) wr_d = step(wr_q);
      if (do_pop)  rd_d = step(rd_q);
      count_next = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= count_next;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !do_flush) begin
      mem[wr_q] <= push_data;
    end
  end

  assign head_data = mem[rd_q];
  assign count     = cnt_q;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_wr,
  input  rxq_flags_t       st_bits,
  input  logic             push_ok,
  input  logic             push_drop,
  input  logic             pop_ok,
  input  logic [CNT_W-1:0] count_next,
  input  logic [CNT_W-1:0] level,
  output rxq_flags_t       flags
);

  rxq_flags_t flg_q, flg_d;

  always_comb begin
    flg_d = flg_q;
    if (st_wr) begin
      flg_d.ready = flg_q.ready & st_bits.ready;
      flg_d.full  = flg_q.full  & st_bits.full;
      flg_d.ovr   = flg_q.ovr   & st_bits.ovr;
    end
    if (pop_ok) begin
      flg_d.full = 1'b0;
      if (count_next == '0) flg_d.ready = 1'b0;
    end
    if (push_ok) begin
      if (count_next >= level) flg_d.full  = 1'b1;
      else                     flg_d.ready = 1'b1;
    end
    if (push_drop) begin
      flg_d.ovr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;

endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flush,
  input  logic              st_wr,
  input  logic              st_ready_wr,
  input  logic              st_full_wr,
  input  logic              st_ovr_wr,
  input  logic              mode_wr,
  input  logic [1:0]        mode_code,
  input  logic              mode_sel,
  input  logic              count_wr,
  input  logic [CNT_W-1:0]  count_val,
  output logic [CNT_W-1:0]  occupancy,
  output logic              ready_flag,
  output logic              full_flag,
  output logic              overrun_flag
);

  logic [CNT_W-1:0]  level, cnt, cnt_next;
  logic [DATA_W-1:0] head;
  logic              pop_ok, push_req, push_ok, push_drop, is_empty;
  rxq_flags_t        st_bits, flags;

  assign is_empty  = (cnt == '0);
  assign pop_ok    = rd_pop && !is_empty && !flush;
  assign push_req  = in_valid && rx_en && !flush;
  assign push_ok   = push_req && ((cnt < CNT_W'(DEPTH)) || pop_ok);
  assign push_drop = push_req && !push_ok;
  assign st_bits   = '{ready: st_ready_wr, full: st_full_wr, ovr: st_ovr_wr};

  rxq_cfg #(.CNT_W(CNT_W), .CNT_RST((1 << CNT_W) - 1)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_code (mode_code),
    .mode_sel  (mode_sel),
    .count_wr  (count_wr),
    .count_val (count_val),
    .level     (level)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .do_push    (push_ok),
    .do_pop     (pop_ok),
    .do_flush   (flush),
    .push_data  (in_byte),
    .head_data  (head),
    .count      (cnt),
    .count_next (cnt_next)
  );

  rxq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_wr      (st_wr),
    .st_bits    (st_bits),
    .push_ok    (push_ok),
    .push_drop  (push_drop),
    .pop_ok     (pop_ok),
    .count_next (cnt_next),
    .level      (level),
    .flags      (flags)
  );

  assign rd_data      = is_empty ? '0 : head;
  assign occupancy    = cnt;
  assign ready_flag   = flags.ready;
  assign full_flag    = flags.full;
  assign overrun_flag = flags.ovr;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              in_valid,
  input logic              rd_pop,
  input logic              flush,
  input logic              st_wr,
  input logic              st_ready_wr,
  input logic              st_ovr_wr,
  input logic [DATA_W-1:0] rd_data,
  input logic [CNT_W-1:0]  occupancy,
  input logic              ready_flag,
  input logic              full_flag,
  input logic              overrun_flag
);

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  assert_disabled_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_pop && !flush) |=> $stable(occupancy));

  assert_pop_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && occupancy != '0 && !flush && !(rx_en && in_valid)) |=> !full_flag);

  assert_empty_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> (rd_data == '0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && in_valid && occupancy == CNT_W'(DEPTH) && !rd_pop && !flush) |=> overrun_flag);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_flag && !(st_wr && !st_ovr_wr)) |=> overrun_flag);

  assert_ready_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_flag && !rd_pop && !(st_wr && !st_ready_wr)) |=> ready_flag);

endmodule

bind rxq_trigger_fifo rxq_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_en        (rx_en),
  .in_valid     (in_valid),
  .rd_pop       (rd_pop),
  .flush        (flush),
  .st_wr        (st_wr),
  .st_ready_wr  (st_ready_wr),
  .st_ovr_wr    (st_ovr_wr),
  .rd_data      (rd_data),
  .occupancy    (occupancy),
  .ready_flag   (ready_flag),
  .full_flag    (full_flag),
  .overrun_flag (overrun_flag)
);

// File: tb/sim_rxq_trigger_fifo.sv
module sim_rxq_trigger_fifo;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_en, in_valid, rd_pop, flush;
  logic [7:0] in_byte, rd_data;
  logic       st_wr, st_ready_wr, st_full_wr, st_ovr_wr;
  logic       mode_wr, mode_sel, count_wr;
  logic [1:0] mode_code;
  logic [4:0] count_val, occupancy;
  logic       ready_flag, full_flag, overrun_flag;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  rxq_trigger_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_valid(in_valid), .in_byte(in_byte),
    .rd_pop(rd_pop), .rd_data(rd_data), .flush(flush),
    .st_wr(st_wr), .st_ready_wr(st_ready_wr), .st_full_wr(st_full_wr), .st_ovr_wr(st_ovr_wr),
    .mode_wr(mode_wr), .mode_code(mode_code), .mode_sel(mode_sel),
    .count_wr(count_wr), .count_val(count_val),
    .occupancy(occupancy), .ready_flag(ready_flag), .full_flag(full_flag),
    .overrun_flag(overrun_flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    d = rd_data;
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic st_write(input logic r, input logic f, input logic o);
    st_wr = 1'b1; st_ready_wr = r; st_full_wr = f; st_ovr_wr = o;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] c, input logic s);
    mode_wr = 1'b1; mode_code = c; mode_sel = s;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic set_count(input logic [4:0] v);
    count_wr = 1'b1; count_val = v;
    @(negedge clk);
    count_wr = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic clear_all();
    do_flush();
    st_write(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R11 occupancy", occupancy, 0);
    chk("R11 ready", ready_flag, 0);
    chk("R11 full", full_flag, 0);
    chk("R11 overrun", overrun_flag, 0);
    chk("R7 empty data", rd_data, 0);
  endtask

  task automatic t_direct_reset_value();
    logic [7:0] d;
    set_mode(2'd0, 1'b1);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    chk("R4 level 31 no full", full_flag, 0);
    chk("R5 ready below level", ready_flag, 1);
    chk("R1 occupancy 16", occupancy, 16);
    push(8'hEE);
    chk("R9 overrun set", overrun_flag, 1);
    chk("R9 occupancy held", occupancy, 16);
    for (int i = 0; i < 16; i++) begin
      pop(d);
      chk("R1 order", d, 8'h10 + 8'(i));
    end
    chk("R6 ready cleared on empty", ready_flag, 0);
    chk("R9 overrun sticky", overrun_flag, 1);
    st_write(1'b1, 1'b1, 1'b1);
    chk("R10 write one keeps overrun", overrun_flag, 1);
    st_write(1'b1, 1'b1, 1'b0);
    chk("R9 overrun cleared by zero", overrun_flag, 0);
  endtask

  task automatic t_coded_levels();
    int lvl;
    for (int c = 0; c < 4; c++) begin
      clear_all();
      set_mode(2'(c), 1'b0);
      lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      for (int i = 0; i < lvl - 1; i++) push(8'(i));
      chk("R3 below level no full", full_flag, 0);
      push(8'hA5);
      chk("R3 level reached full", full_flag, 1);
      chk("R3 occupancy at level", occupancy, 5'(lvl));
      if (c == 0) chk("R5 ready not set at level", ready_flag, 0);
      else        chk("R5 ready set below level", ready_flag, 1);
    end
  endtask

  task automatic t_direct_count();
    clear_all();
    set_count(5'd3);
    set_mode(2'd3, 1'b1);
    push(8'h01); push(8'h02);
    chk("R4 direct below", full_flag, 0);
    push(8'h03);
    chk("R4 direct at level", full_flag, 1);
  endtask

  task automatic t_pop_flags();
    logic [7:0] d;
    clear_all();
    set_mode(2'd2, 1'b0);
    for (int i = 0; i < 8; i++) push(8'h40 + 8'(i));
    chk("R5 full at 8", full_flag, 1);
    pop(d);
    chk("R1 first out", d, 8'h40);
    chk("R6 pop clears full", full_flag, 0);
    chk("R6 ready kept non-empty", ready_flag, 1);
    for (int i = 1; i < 8; i++) pop(d);
    chk("R1 last out", d, 8'h47);
    chk("R6 ready cleared empty", ready_flag, 0);
    chk("R6 occupancy zero", occupancy, 0);
  endtask

  task automatic t_empty_read();
    logic [7:0] d;
    pop(d);
    chk("R7 empty read zero", d, 0);
    chk("R7 occupancy unchanged", occupancy, 0);
    chk("R7 flags unchanged", {ready_flag, full_flag}, 0);
  endtask

  task automatic t_disabled();
    clear_all();
    rx_en = 1'b0;
    push(8'h11); push(8'h22); push(8'h33);
    chk("R2 occupancy stays", occupancy, 0);
    chk("R2 ready stays", ready_flag, 0);
    rx_en = 1'b1;
  endtask

  task automatic t_flush();
    clear_all();
    push(8'h55); push(8'h66);
    chk("R8 ready before flush", ready_flag, 1);
    do_flush();
    chk("R8 flush empties", occupancy, 0);
    chk("R8 flags unchanged", ready_flag, 1);
    chk("R8 data zero after flush", rd_data, 0);
  endtask

  task automatic t_status();
    st_write(1'b1, 1'b1, 1'b1);
    chk("R10 write one keeps ready", ready_flag, 1);
    st_write(1'b0, 1'b1, 1'b1);
    chk("R10 write zero clears ready", ready_flag, 0);
    set_mode(2'd0, 1'b0);
    push(8'h77);
    chk("R10 full set before clear", full_flag, 1);
    st_write(1'b1, 1'b0, 1'b1);
    chk("R10 write zero clears full", full_flag, 0);
    chk("R10 occupancy unaffected", occupancy, 1);
  endtask

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; in_valid = 1'b0; in_byte = '0; rd_pop = 1'b0; flush = 1'b0;
    st_wr = 1'b0; st_ready_wr = 1'b0; st_full_wr = 1'b0; st_ovr_wr = 1'b0;
    mode_wr = 1'b0; mode_code = '0; mode_sel = 1'b0; count_wr = 1'b0; count_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_reset_value();
    t_coded_levels();
    t_direct_count();
    t_pop_flags();
    t_empty_read();
    t_disabled();
    t_flush();
    t_status();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule